// File: doc/BRIEF.md
# Two-Bucket L2 Slot Search Engine

This block is a sequential search engine for a hashed layer-2 forwarding table. The table holds three-word entries grouped into buckets of four. Every key hashes into two independent halves of the table. The caller supplies one bucket index for each half, plus a 60-bit key made of a 12-bit VLAN/forwarding id and a 48-bit MAC address. After a start pulse the engine reads candidate slots one at a time through a synchronous table read port. It stops at the first slot that is either free or already holds the key.

The result comes back on a one-cycle done pulse. It says whether the slot hit an existing entry, found a free slot, or whether the table is full for this key. It also gives the slot number, the table address of that slot, and whether a matched entry is marked as a next-hop entry. A caller that adds entries uses the free or hit address as its write target. Writing, ageing and overflow storage sit outside this block.

Top module: `l2_bucket_search`

## Requirements
- R1: After reset, and before any start, busy_o, rd_req_o, done_o, hit_o, free_o, full_o and nexthop_o are 0, and slot_o and addr_o are 0.
- R2: Slot p (0 to 7) is read at address {bkt0, p[1:0]} for p < 4 and at {bkt1, p[1:0]} for p >= 4, using the bucket indices latched at start. addr_o reports the address of the chosen slot, and is 0 when the result is full.
- R3: Each slot costs exactly one rd_req_o cycle, and read data is taken from rd_data_i in the cycle after that request. Two requests are never in adjacent cycles, and no request is made while idle.
- R4: A slot whose valid flag (rd_data_i[95], bit 31 of the third word) is 0 qualifies as free, whatever its other bits hold, and gives free_o = 1.
- R5: A valid slot whose identity {rd_data_i[43:32], rd_data_i[31:0], rd_data_i[63:48]} equals key_i[59:0] gives hit_o = 1.
- R6: Slots are examined in ascending order, and the first qualifying slot ends the search. slot_o is its number, and exactly slot_o + 1 reads are made.
- R7: When all 8 slots are valid and none matches, done_o comes with full_o = 1 and slot_o = 0, after exactly 8 reads.
- R8: nexthop_o equals bit 12 of the third word (rd_data_i[76]) of a hit slot, and is 0 for a free or full result.
- R9: done_o is a single-cycle pulse carrying exactly one of hit_o, free_o and full_o. The result outputs hold their value until the next done_o.
- R10: start_i is ignored while busy_o is 1. It neither restarts the search nor alters its result, and no new search follows from it.
- R11: When the search ends at slot k, done_o is 1 in the cycle that begins 2(k+1) clock edges after the edge that accepts start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (accepted only when idle) |
| bkt0_i | input | BKT_W | Bucket index in the first hash half |
| bkt1_i | input | BKT_W | Bucket index in the second hash half |
| key_i | input | 60 | Search key {id[11:0], mac[47:0]} |
| busy_o | output | 1 | Search in progress |
| rd_req_o | output | 1 | Table read request |
| rd_addr_o | output | BKT_W+2 | Table read address |
| rd_data_i | input | 96 | Entry read data, valid the cycle after a request |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Chosen slot holds the key |
| free_o | output | 1 | Chosen slot is empty |
| full_o | output | 1 | No slot qualified |
| slot_o | output | 3 | Number of the chosen slot |
| addr_o | output | BKT_W+2 | Table address of the chosen slot |
| nexthop_o | output | 1 | Hit entry carries the next-hop mark |

## Verification
Some properties are checked on every cycle. These cover the spacing of read requests, the bucket and position encoded in each request address, the single-cycle done pulse with a one-hot outcome, and the agreement between the number of reads, the reported slot and the full case. The bench alone shows that the outcome is right for a given table content. It sweeps every mix of free, matching and non-matching entries over the eight slots, including free slots whose stale identity equals the key and near-miss keys differing in one bit. The bench also covers the exact done latency, next-hop reporting, and starts that arrive during a search and are dropped.

// File: rtl/l2s_pkg.sv
package l2s_pkg;
  localparam int KEY_W     = 60;
  localparam int WORD_W    = 32;
  localparam int ENTRY_W   = 3 * WORD_W;
  localparam int W1_LO     = WORD_W;
  localparam int W2_LO     = 2 * WORD_W;
  localparam int VALID_POS = W2_LO + 31;
  localparam int NH_POS    = W2_LO + 12;
  localparam int ID_W      = 12;
  localparam int MAC_LO_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CHK  = 2'd2
  } state_e;
endpackage

// File: rtl/l2s_slot_eval.sv
module l2s_slot_eval
  import l2s_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic               valid_o,
  output logic               match_o,
  output logic               nh_o,
  output logic               qual_o
);
  logic [KEY_W-1:0] ident;
  logic             unused_bits;

  // identity = {id, mac[47:16], mac[15:0]}
  assign ident = {entry_i[W1_LO +: ID_W],
                  entry_i[0 +: WORD_W],
                  entry_i[W1_LO+WORD_W-MAC_LO_W +: MAC_LO_W]};

  assign valid_o = entry_i[VALID_POS];
  assign match_o = valid_o && (ident == key_i);
  assign nh_o    = entry_i[NH_POS];
  assign qual_o  = !valid_o || match_o;

  assign unused_bits = ^{entry_i[W1_LO+ID_W +: 4],
                         entry_i[W2_LO +: 12],
                         entry_i[W2_LO+13 +: 18]};
endmodule

// File: rtl/l2s_addr_gen.sv
module l2s_addr_gen #(
  parameter int BKT_W = 12,
  parameter int WAYS  = 4,
  localparam int POS_W  = $clog2(WAYS),
  localparam int SLOT_W = POS_W + 1,
  localparam int ADDR_W = BKT_W + POS_W
) (
  input  logic [BKT_W-1:0]  bkt0_i,
  input  logic [BKT_W-1:0]  bkt1_i,
  input  logic [SLOT_W-1:0] pos_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BKT_W-1:0] sel_bkt;

  assign sel_bkt = pos_i[SLOT_W-1] ? bkt1_i : bkt0_i;

  generate
    if (POS_W > 0) begin : g_multi_way
      assign addr_o = {sel_bkt, pos_i[POS_W-1:0]};
    end else begin : g_single_way
      assign addr_o = sel_bkt;
    end
  endgenerate
endmodule

// File: rtl/l2s_ctrl.sv
module l2s_ctrl
  import l2s_pkg::*;
#(
  parameter int BKT_W = 12,
  parameter int WAYS  = 4,
  localparam int POS_W     = $clog2(WAYS),
  localparam int SLOT_W    = POS_W + 1,
  localparam int ADDR_W    = BKT_W + POS_W,
  localparam int NUM_SLOTS = 2 * WAYS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BKT_W-1:0]  bkt0_i,
  input  logic [BKT_W-1:0]  bkt1_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              qual_i,
  input  logic              valid_i,
  input  logic              nh_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [SLOT_W-1:0] pos_o,
  output logic [BKT_W-1:0]  bkt0_o,
  output logic [BKT_W-1:0]  bkt1_o,
  output logic [KEY_W-1:0]  key_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              free_o,
  output logic              full_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              nexthop_o
);
  localparam logic [SLOT_W-1:0] LAST_POS = SLOT_W'(NUM_SLOTS - 1);

  state_e            state_q;
  logic [SLOT_W-1:0] pos_q;
  logic [BKT_W-1:0]  bkt0_q, bkt1_q;
  logic [KEY_W-1:0]  key_q;
  logic              done_q, hit_q, free_q, full_q, nh_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last_slot;

  assign last_slot = (pos_q == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      bkt0_q  <= '0;
      bkt1_q  <= '0;
      key_q   <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      free_q  <= 1'b0;
      full_q  <= 1'b0;
      nh_q    <= 1'b0;
      slot_q  <= '0;
      addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_REQ;
            pos_q   <= '0;
            bkt0_q  <= bkt0_i;
            bkt1_q  <= bkt1_i;
            key_q   <= key_i;
          end
        end
        ST_REQ: state_q <= ST_CHK;
        ST_CHK: begin
          if (qual_i || last_slot) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            hit_q   <= qual_i && valid_i;
            free_q  <= qual_i && !valid_i;
            full_q  <= !qual_i;
            nh_q    <= qual_i && valid_i && nh_i;
            slot_q  <= qual_i ? pos_q : '0;
            addr_q  <= qual_i ? cur_addr_i : '0;
          end else begin
            pos_q   <= pos_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rd_req_o  = (state_q == ST_REQ);
  assign pos_o     = pos_q;
  assign bkt0_o    = bkt0_q;
  assign bkt1_o    = bkt1_q;
  assign key_o     = key_q;
  assign done_o    = done_q;
  assign hit_o     = hit_q;
  assign free_o    = free_q;
  assign full_o    = full_q;
  assign slot_o    = slot_q;
  assign addr_o    = addr_q;
  assign nexthop_o = nh_q;
endmodule

// File: rtl/l2_bucket_search.sv
module l2_bucket_search
  import l2s_pkg::*;
#(
  parameter int BKT_W = 12,
  parameter int WAYS  = 4,
  localparam int POS_W  = $clog2(WAYS),
  localparam int SLOT_W = POS_W + 1,
  localparam int ADDR_W = BKT_W + POS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BKT_W-1:0]   bkt0_i,
  input  logic [BKT_W-1:0]   bkt1_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic               busy_o,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [ENTRY_W-1:0] rd_data_i,
  output logic               done_o,
  output logic               hit_o,
  output logic               free_o,
  output logic               full_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               nexthop_o
);
  logic [SLOT_W-1:0] pos;
  logic [BKT_W-1:0]  bkt0_q, bkt1_q;
  logic [KEY_W-1:0]  key_q;
  logic              slot_valid, slot_match, slot_nh, slot_qual;

  l2s_addr_gen #(.BKT_W(BKT_W), .WAYS(WAYS)) u_addr (
    .bkt0_i (bkt0_q),
    .bkt1_i (bkt1_q),
    .pos_i  (pos),
    .addr_o (rd_addr_o)
  );

  l2s_slot_eval u_eval (
    .entry_i (rd_data_i),
    .key_i   (key_q),
    .valid_o (slot_valid),
    .match_o (slot_match),
    .nh_o    (slot_nh),
    .qual_o  (slot_qual)
  );

  l2s_ctrl #(.BKT_W(BKT_W), .WAYS(WAYS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bkt0_i     (bkt0_i),
    .bkt1_i     (bkt1_i),
    .key_i      (key_i),
    .qual_i     (slot_qual),
    .valid_i    (slot_valid),
    .nh_i       (slot_nh && slot_match),
    .cur_addr_i (rd_addr_o),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .pos_o      (pos),
    .bkt0_o     (bkt0_q),
    .bkt1_o     (bkt1_q),
    .key_o      (key_q),
    .done_o     (done_o),
    .hit_o      (hit_o),
    .free_o     (free_o),
    .full_o     (full_o),
    .slot_o     (slot_o),
    .addr_o     (addr_o),
    .nexthop_o  (nexthop_o)
  );
endmodule

// File: rtl/l2s_checker.sv
module l2s_checker #(
  parameter int BKT_W = 12,
  parameter int WAYS  = 4,
  localparam int POS_W     = $clog2(WAYS),
  localparam int SLOT_W    = POS_W + 1,
  localparam int ADDR_W    = BKT_W + POS_W,
  localparam int NUM_SLOTS = 2 * WAYS,
  localparam int CNT_W     = $clog2(NUM_SLOTS) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [BKT_W-1:0]  bkt0_i,
  input logic [BKT_W-1:0]  bkt1_i,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              done_o,
  input logic              hit_o,
  input logic              free_o,
  input logic              full_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              nexthop_o
);
  logic [CNT_W-1:0] req_cnt;
  logic [BKT_W-1:0] b0_q, b1_q;
  logic [BKT_W-1:0] exp_bkt;
  logic [BKT_W-1:0] res_bkt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cnt <= '0;
      b0_q    <= '0;
      b1_q    <= '0;
    end else if (start_i && !busy_o) begin
      req_cnt <= '0;
      b0_q    <= bkt0_i;
      b1_q    <= bkt1_i;
    end else if (rd_req_o) begin
      req_cnt <= req_cnt + 1'b1;
    end
  end

  assign exp_bkt = (req_cnt < CNT_W'(WAYS)) ? b0_q : b1_q;
  assign res_bkt = slot_o[SLOT_W-1] ? b1_q : b0_q;

  p_no_req_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o);

  p_req_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  p_req_bucket_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[ADDR_W-1 -: BKT_W] == exp_bkt);

  p_req_way_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[POS_W-1:0] == req_cnt[POS_W-1:0]);

  p_res_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !full_o) |-> addr_o == {res_bkt, slot_o[POS_W-1:0]});

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({hit_o, free_o, full_o}));

  p_first_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !full_o) |-> req_cnt == CNT_W'(slot_o) + CNT_W'(1));

  p_full_reads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && full_o) |-> (req_cnt == CNT_W'(NUM_SLOTS)) && (slot_o == '0));

  p_nh_only_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> !nexthop_o);

  p_done_ends_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind l2_bucket_search l2s_checker #(.BKT_W(BKT_W), .WAYS(WAYS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .bkt0_i    (bkt0_i),
  .bkt1_i    (bkt1_i),
  .busy_o    (busy_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .done_o    (done_o),
  .hit_o     (hit_o),
  .free_o    (free_o),
  .full_o    (full_o),
  .slot_o    (slot_o),
  .addr_o    (addr_o),
  .nexthop_o (nexthop_o)
);

// File: tb/l2_bucket_search_tb.sv
`timescale 1ns/1ps
module l2_bucket_search_tb;
  localparam int BKT_W  = 12;
  localparam int ADDR_W = BKT_W + 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [BKT_W-1:0]  bkt0_i = '0, bkt1_i = '0;
  logic [59:0]       key_i = '0;
  logic              busy_o, rd_req_o, done_o, hit_o, free_o, full_o, nexthop_o;
  logic [ADDR_W-1:0] rd_addr_o, addr_o;
  logic [95:0]       rd_data_i = '0;
  logic [2:0]        slot_o;

  int checks = 0;
  int fails  = 0;

  logic [95:0]      ent [8];
  logic [BKT_W-1:0] m_b0, m_b1;

  always #10 clk_i = ~clk_i;

  l2_bucket_search #(.BKT_W(BKT_W), .WAYS(4)) u_dut (
    .clk_i, .rst_ni, .start_i, .bkt0_i, .bkt1_i, .key_i,
    .busy_o, .rd_req_o, .rd_addr_o, .rd_data_i,
    .done_o, .hit_o, .free_o, .full_o, .slot_o, .addr_o, .nexthop_o
  );

  function automatic logic [95:0] lookup(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:2] == m_b0)      return ent[{1'b0, a[1:0]}];
    else if (a[ADDR_W-1:2] == m_b1) return ent[{1'b1, a[1:0]}];
    else                            return 96'h0;
  endfunction

  always @(posedge clk_i) rd_data_i <= rd_req_o ? lookup(rd_addr_o) : 96'h0;

  function automatic logic [95:0] mk_entry(input logic vld, input logic [59:0] id,
                                           input logic nh, input logic [11:0] fill);
    logic [95:0] e;
    e = '0;
    e[31:0]  = id[47:16];
    e[63:48] = id[15:0];
    e[43:32] = id[59:48];
    e[75:64] = fill;
    e[76]    = nh;
    e[95]    = vld;
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 = valid non-matching, 1 = valid match, 2 = free
  task automatic run_cfg(input int cfg, input bit poke);
    int kind [8];
    int t, k, cnt, reads;
    bit nhs [8];
    logic [59:0] key;
    logic [ADDR_W-1:0] exp_addr;
    t = cfg;
    for (int s = 0; s < 8; s++) begin kind[s] = t % 3; t = t / 3; end
    key  = {12'(cfg) ^ 12'h5a5, 16'(cfg * 37) ^ 16'hc0de, 32'h1234_5678 + 32'(cfg * 977)};
    m_b0 = 12'(cfg * 5 + 3);
    m_b1 = m_b0 ^ 12'ha00;
    k = 8;
    for (int s = 0; s < 8; s++) begin
      nhs[s] = 1'((s + cfg) & 1);
      case (kind[s])
        0: ent[s] = mk_entry(1'b1, key ^ (60'd1 << ((cfg * 7 + s) % 60)), nhs[s], 12'(s));
        1: ent[s] = mk_entry(1'b1, key, nhs[s], 12'(cfg));
        default: ent[s] = mk_entry(1'b0, ((cfg + s) % 2 == 1) ? key : ~key, 1'b1, 12'hfff);
      endcase
      if (k == 8 && kind[s] != 0) k = s;
    end
    @(negedge clk_i);
    start_i = 1'b1; key_i = key; bkt0_i = m_b0; bkt1_i = m_b1;
    cnt = 0; reads = 0;
    while (cnt < 40) begin
      @(negedge clk_i);
      cnt++;
      start_i = 1'b0;
      if (poke && cnt == 2) begin
        start_i = 1'b1; key_i = ~key; bkt0_i = ~m_b0; bkt1_i = ~m_b1;
      end
      if (rd_req_o) begin
        exp_addr = {(reads < 4) ? m_b0 : m_b1, 2'(reads)};
        chk("R2 read address", 64'(rd_addr_o), 64'(exp_addr));
        reads++;
      end
      if (done_o) break;
    end
    start_i = 1'b0;
    chk("R11 done latency", 64'(cnt), 64'(2 * ((k < 8) ? k : 7) + 3));
    chk("R6 R3 read count", 64'(reads), 64'((k < 8) ? k + 1 : 8));
    if (k == 8) begin
      chk("R7 full outcome", 64'({hit_o, free_o, full_o, slot_o}), 64'({3'b001, 3'd0}));
      chk("R2 full addr", 64'(addr_o), 64'd0);
    end else if (kind[k] == 1) begin
      chk("R5 hit outcome", 64'({hit_o, free_o, full_o, slot_o}), 64'({3'b100, 3'(k)}));
      chk("R2 hit addr", 64'(addr_o), 64'({(k < 4) ? m_b0 : m_b1, 2'(k)}));
    end else begin
      chk("R4 free outcome", 64'({hit_o, free_o, full_o, slot_o}), 64'({3'b010, 3'(k)}));
      chk("R2 free addr", 64'(addr_o), 64'({(k < 4) ? m_b0 : m_b1, 2'(k)}));
    end
    chk("R8 nexthop", 64'(nexthop_o), 64'((k < 8 && kind[k] == 1) ? nhs[k] : 1'b0));
    if (poke) begin
      logic [5:0] held;
      held = {hit_o, free_o, full_o, slot_o};
      @(negedge clk_i);
      chk("R9 done pulse", 64'(done_o), 64'd0);
      chk("R10 no restart", 64'({busy_o, rd_req_o}), 64'd0);
      chk("R9 result held", 64'({hit_o, free_o, full_o, slot_o}), 64'(held));
    end
  endtask

  initial begin
    #(20 * 195000);
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    m_b0 = '0; m_b1 = '1;
    for (int s = 0; s < 8; s++) ent[s] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", 64'({busy_o, rd_req_o, done_o, hit_o, free_o, full_o, nexthop_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle outputs", 64'({busy_o, rd_req_o, done_o, hit_o, free_o, full_o, nexthop_o, slot_o, addr_o}), 64'd0);
    for (int cfg = 0; cfg < 6561; cfg++) run_cfg(cfg, (cfg % 5) == 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule